// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. By default it holds 512 words of 9 bits. Four active-low status outputs report its fill level: empty and near-empty are produced in the read clock domain, and full and near-full in the write clock domain. The two near-flags compare the fill level against two threshold registers that software can load. Pointers pass between the clock domains as Gray code through two-flop synchronisers. Because of this, a flag may clear a few cycles late, but it never reports a state that is not safe.

One input, `aux_en`, has two uses. The block samples it while reset is held and keeps that choice until the next reset.

- **Two-enable mode** (`aux_en` high during reset): `aux_en` is a second write enable.
- **Threshold mode** (`aux_en` low during reset): driving `aux_en` low makes the write port load the two thresholds and the read port return them, one after the other, instead of using the buffer.

An output-drive enable models a tri-state bus as a value plus a valid flag.

Top module: `dc_fifo_pflag`

## Requirements
- R1: While `rst_n` is low, `aux_en` high selects two-enable mode and `aux_en` low selects threshold mode. The mode does not change until the next reset. In two-enable mode, `aux_en` has no effect on reads.
- R2: A word on `din` is stored at a rising `wr_clk` edge exactly when `wr_en_n`=0, `aux_en`=1 and `full_n`=1.
- R3: A word is delivered at a rising `rd_clk` edge exactly when `rd_en0_n`=0, `rd_en1_n`=0, `empty_n`=1 and no threshold readback is selected. `q` then holds that word, in write order. If only one read enable is low, nothing is read.
- R4: A write while `full_n`=0 or a read while `empty_n`=0 is ignored. No word is lost or duplicated, and `q` keeps its value.
- R5: After reset, the buffer is empty and the outputs are `empty_n`=0, `near_empty_n`=0, `full_n`=1, `near_full_n`=1, with `q`=0 while driven. Both thresholds are 7.
- R6: `empty_n` and `near_empty_n` change only on `rd_clk`, and `full_n` and `near_full_n` change only on `wr_clk`. After a write into an empty buffer, `empty_n` rises between 2 and 5 `rd_clk` cycles later.
- R7: Once the flags have settled, `near_empty_n` is 0 exactly when the fill level is less than or equal to the near-empty threshold.
- R8: Once the flags have settled, `near_full_n` is 0 exactly when the fill level is greater than or equal to depth minus the near-full threshold. `full_n` is 0 exactly when the fill level equals the depth.
- R9: In threshold mode with `aux_en`=0, each `wr_clk` edge with `wr_en_n`=0 loads the low AW bits of `din` into a threshold. The loads alternate: near-empty first, then near-full, then near-empty again. The buffer is not touched.
- R10: In threshold mode with `aux_en`=0, each `rd_clk` edge with both read enables low puts a threshold on `q`, zero-extended. The order is near-empty first, then near-full, alternating, using a separate read-side index. The buffer is not touched.
- R11: When `drive_n`=1, `q`=0 and `q_valid`=0. When `drive_n`=0, `q` shows the output register and `q_valid`=1.
- R12: In two-enable mode, `aux_en`=0 blocks writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, synchronous in each domain; both clocks must run while it is held |
| din | input | DW | Write data, or threshold value during a load |
| wr_en_n | input | 1 | Active-low write enable |
| aux_en | input | 1 | Mode pin sampled at reset; then second write enable, or active-low threshold access |
| rd_en0_n | input | 1 | Active-low read enable, first of two |
| rd_en1_n | input | 1 | Active-low read enable, second of two |
| drive_n | input | 1 | Active-low output drive enable |
| q | output | DW | Read data or threshold readback, 0 when not driven |
| q_valid | output | 1 | High when `q` is driven |
| empty_n | output | 1 | Low when the buffer is empty (read domain) |
| full_n | output | 1 | Low when the buffer is full (write domain) |
| near_empty_n | output | 1 | Low when the fill level is at or below the near-empty threshold (read domain) |
| near_full_n | output | 1 | Low when the fill level is within the near-full threshold of full (write domain) |

## Verification
- **Read data and readback values** are due on `q` right after the `rd_clk` edge that performs the read. The bench samples them at the following falling edge.
- **Writes and loads** take effect at the `wr_clk` edge between two falling edges, which is when the bench drives them.
- **Flags in the opposite domain** are due only after two synchroniser stages and the flag register. Before every flag check, the bench waits five cycles of each clock, so every flag is compared against the fill level computed from its own count of writes and reads.
- **Empty-flag latency** (R6) is measured separately, by counting `rd_clk` cycles until `empty_n` rises and checking the count against a window.

// File: rtl/dc_fifo_pflag.sv
module dc_fifo_pflag #(
  parameter int DW = 9,
  parameter int AW = 9,
  parameter int NE_DEF = 7,
  parameter int NF_DEF = 7
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wr_en_n,
  input  logic          aux_en,
  input  logic          rd_en0_n,
  input  logic          rd_en1_n,
  input  logic          drive_n,
  output logic [DW-1:0] q,
  output logic          q_valid,
  output logic          empty_n,
  output logic          full_n,
  output logic          near_empty_n,
  output logic          near_full_n
);
  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic          prog_w, ld_idx_w;
  logic [PW-1:0] wptr, wgray, rg_s1, rg_s2;
  logic [AW-1:0] ne_off, nf_off;
  logic          full_q, nfull_q;

  wire           wr_do   = !wr_en_n && aux_en && full_q;
  wire           ld_do   = prog_w && !aux_en && !wr_en_n;
  wire [PW-1:0]  wptr_nx = wptr + PW'(wr_do);
  wire [PW-1:0]  rsync_b = to_bin(rg_s2);
  wire [PW-1:0]  wfill   = wptr - rsync_b;
  wire [PW-1:0]  wfill_nx = wptr_nx - rsync_b;

  always_ff @(posedge wr_clk) begin
    if (!rst_n) begin
      prog_w   <= !aux_en;
      ld_idx_w <= 1'b0;
      wptr     <= '0;
      wgray    <= '0;
      rg_s1    <= '0;
      rg_s2    <= '0;
      ne_off   <= AW'(NE_DEF);
      nf_off   <= AW'(NF_DEF);
      full_q   <= 1'b1;
      nfull_q  <= 1'b1;
    end else begin
      rg_s1   <= rgray;
      rg_s2   <= rg_s1;
      wptr    <= wptr_nx;
      wgray   <= to_gray(wptr_nx);
      full_q  <= (wfill_nx != DEPTH_P);
      nfull_q <= (wfill_nx < (DEPTH_P - {1'b0, nf_off}));
      if (ld_do) begin
        if (ld_idx_w) nf_off <= din[AW-1:0];
        else          ne_off <= din[AW-1:0];
        ld_idx_w <= !ld_idx_w;
      end
    end
  end

  always_ff @(posedge wr_clk)
    if (rst_n && wr_do) mem[wptr[AW-1:0]] <= din;

  // read domain
  logic          prog_r, rb_idx;
  logic [PW-1:0] rptr, rgray, wg_s1, wg_s2;
  logic          empty_q, nempty_q;
  logic [DW-1:0] q_reg;

  wire           rd_pins = !rd_en0_n && !rd_en1_n;
  wire           rb_do   = prog_r && !aux_en && rd_pins;
  wire           rd_do   = rd_pins && empty_q && !rb_do;
  wire [PW-1:0]  rptr_nx = rptr + PW'(rd_do);
  wire [PW-1:0]  rfill_nx = to_bin(wg_s2) - rptr_nx;

  always_ff @(posedge rd_clk) begin
    if (!rst_n) begin
      prog_r   <= !aux_en;
      rb_idx   <= 1'b0;
      rptr     <= '0;
      rgray    <= '0;
      wg_s1    <= '0;
      wg_s2    <= '0;
      empty_q  <= 1'b0;
      nempty_q <= 1'b0;
      q_reg    <= '0;
    end else begin
      wg_s1    <= wgray;
      wg_s2    <= wg_s1;
      rptr     <= rptr_nx;
      rgray    <= to_gray(rptr_nx);
      empty_q  <= (rfill_nx != '0);
      nempty_q <= (rfill_nx > {1'b0, ne_off});
      if (rd_do) q_reg <= mem[rptr[AW-1:0]];
      else if (rb_do) begin
        q_reg  <= rb_idx ? DW'(nf_off) : DW'(ne_off);
        rb_idx <= !rb_idx;
      end
    end
  end

  assign empty_n      = empty_q;
  assign near_empty_n = nempty_q;
  assign full_n       = full_q;
  assign near_full_n  = nfull_q;
  assign q_valid      = !drive_n;
  assign q            = drive_n ? '0 : q_reg;

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_q && !wr_en_n) |=> $stable(wptr)); // R4
  AST_FILL_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wfill <= DEPTH_P); // R4
  AST_LOAD_KEEPS_WPTR: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ld_do |=> $stable(wptr)); // R9
  AST_MODE_FIXED: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(prog_w)); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_q && rd_pins) |=> $stable(rptr)); // R4
  AST_READBACK_KEEPS_RPTR: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rb_do |=> $stable(rptr)); // R10
  AST_EMPTY_IMPLIES_NEAR: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_q |-> !nempty_q); // R7
endmodule

// File: tb/dc_fifo_pflag_tb.sv
`timescale 1ns/1ps
module dc_fifo_pflag_tb;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic [DW-1:0] din = '0;
  logic wr_en_n = 1, aux_en = 1, rd_en0_n = 1, rd_en1_n = 1, drive_n = 0;
  logic [DW-1:0] q;
  logic q_valid, empty_n, full_n, near_empty_n, near_full_n;

  int total = 0, failed = 0;
  bit done = 0;

  always #2 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  dc_fifo_pflag #(.DW(DW), .AW(AW), .NE_DEF(7), .NF_DEF(7)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .din(din),
    .wr_en_n(wr_en_n), .aux_en(aux_en), .rd_en0_n(rd_en0_n), .rd_en1_n(rd_en1_n),
    .drive_n(drive_n), .q(q), .q_valid(q_valid), .empty_n(empty_n),
    .full_n(full_n), .near_empty_n(near_empty_n), .near_full_n(near_full_n));

  function automatic logic [DW-1:0] val(input int n);
    return DW'((n * 37 + 5) % 512);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pin);
    rst_n = 0;
    aux_en = pin;
    repeat (4) @(negedge rd_clk);
    rst_n = 1;
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic wr_word(input logic [DW-1:0] d);
    @(negedge wr_clk);
    din = d;
    wr_en_n = 0;
    @(negedge wr_clk);
    wr_en_n = 1;
  endtask

  task automatic rd_word(output logic [DW-1:0] d);
    @(negedge rd_clk);
    rd_en0_n = 0;
    rd_en1_n = 0;
    @(negedge rd_clk);
    rd_en0_n = 1;
    rd_en1_n = 1;
    d = q;
  endtask

  task automatic settle();
    repeat (5) @(negedge rd_clk);
    repeat (5) @(negedge wr_clk);
  endtask

  task automatic set_aux(input logic v);
    @(negedge wr_clk);
    aux_en = v;
    settle();
  endtask

  task automatic flags(input int fill, input int ne, input int nf);
    check("R6 empty_n", empty_n, fill > 0);
    check("R7 near_empty_n", near_empty_n, fill > ne);
    check("R8 full_n", full_n, fill < DEPTH);
    check("R8 near_full_n", near_full_n, fill < DEPTH - nf);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failed++;
      total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    int cnt;

    // two-enable mode
    do_reset(1'b1);
    check("R5 empty_n", empty_n, 0);
    check("R5 near_empty_n", near_empty_n, 0);
    check("R5 full_n", full_n, 1);
    check("R5 near_full_n", near_full_n, 1);
    check("R5 q", q, 0);

    for (int n = 1; n <= DEPTH; n++) begin
      wr_word(val(n));
      settle();
      flags(n, 7, 7);
    end
    wr_word(9'h1AA);
    settle();
    check("R4 full after overflow", full_n, 0);
    for (int n = 1; n <= DEPTH; n++) begin
      rd_word(v);
      check("R3 read order", v, val(n));
      settle();
      flags(DEPTH - n, 7, 7);
    end
    rd_word(v);
    check("R4 q kept on underflow", v, val(DEPTH));
    settle();
    check("R4 empty after drain", empty_n, 0);

    wr_word(9'h0F0);
    cnt = 0;
    while (!empty_n && cnt < 10) begin
      @(negedge rd_clk);
      cnt++;
    end
    check("R6 empty latency window", (cnt >= 2 && cnt <= 5) ? 1 : 0, 1);
    rd_word(v);
    check("R2 stored word", v, 9'h0F0);
    settle();

    set_aux(1'b0);
    wr_word(9'h133);
    settle();
    check("R12 second enable blocks", empty_n, 0);
    set_aux(1'b1);

    wr_word(9'h055);
    settle();
    @(negedge rd_clk);
    rd_en0_n = 0;
    @(negedge rd_clk);
    rd_en0_n = 1;
    settle();
    check("R3 single enable no read", empty_n, 1);
    check("R3 q unchanged", q, 9'h0F0);
    rd_word(v);
    check("R3 word after partial", v, 9'h055);
    settle();

    wr_word(9'h066);
    settle();
    set_aux(1'b0);
    rd_word(v);
    check("R1 aux ignored by reads", v, 9'h066);
    set_aux(1'b1);

    drive_n = 1;
    #1;
    check("R11 q when off", q, 0);
    check("R11 valid when off", q_valid, 0);
    drive_n = 0;
    #1;
    check("R11 q when on", q, 9'h066);
    check("R11 valid when on", q_valid, 1);

    // threshold mode
    do_reset(1'b0);
    rd_word(v);
    check("R10 default near-empty", v, 7);
    rd_word(v);
    check("R10 default near-full", v, 7);
    wr_word(9'h003);
    wr_word(9'h00A);
    settle();
    rd_word(v);
    check("R10 readback near-empty", v, 3);
    rd_word(v);
    check("R10 readback near-full", v, 10);
    rd_word(v);
    check("R10 index wraps", v, 3);
    settle();
    check("R9 buffer untouched", empty_n, 0);
    set_aux(1'b1);
    for (int n = 1; n <= DEPTH; n++) begin
      wr_word(val(n + 40));
      settle();
      flags(n, 3, 10);
    end
    for (int n = 1; n <= DEPTH; n++) begin
      rd_word(v);
      check("R3 read order threshold mode", v, val(n + 40));
    end
    settle();
    flags(0, 3, 10);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule